// File: doc/BRIEF.md
# Segment store interleaver

This block sits in front of a segmented unit-stride vector store. Software keeps a segment as several register groups, one per field: group k holds field k of every struct. Memory wants the structs whole, with their fields side by side. The block reads the field groups through a simple register-file read port. It then writes a run of internal buffer registers, each VLEN bits wide, which together hold the structs packed back to back. A later store stage can stream those registers to memory unchanged.

A job begins with a one-cycle start pulse that carries four things: the element width code, the encoded field count, the active vector length and the base register. The work is split into register groups, one for each VLEN-sized chunk of the vector length. For each group the block first reads every field register of that group, one per cycle, into a capture buffer. It then emits one buffer register per field, one per cycle. Each output register is filled by a round-robin walk over the captured field registers. The walk starts at a position derived from the output's chunk number. A done pulse follows the last write. Address generation, masking and the memory write itself belong to other blocks.

Top module: `segst_interleave`

## Requirements
- R1: The field count is the 3-bit `nf_enc_i` plus one. For each register group the block reads exactly that many source registers.
- R2: Element width code 0, 1, 2, 3 on `ew_i` means 8, 16, 32, 64 bits. A register holds VLEN/width elements. The job covers ceil(vl/(VLEN/width)) register groups and writes field-count times that many buffer registers.
- R3: In group m the block reads field j (j = 0 upward, one per cycle, starting the cycle after start is accepted) at register address base + j*groups + m, modulo 32. Read data is taken in the same cycle.
- R4: After the reads of group m, output chunk c (c = 0 upward, one per cycle) is written to buffer index c + m*fields. The next group's reads follow directly.
- R5: With e active elements in the group, output chunk c begins its walk at field (c*e) mod fields and element (c*e) div fields.
- R6: Output element slots are filled from slot 0 upward. After each slot the field advances by one. On passing the last field it returns to field 0 and the element index advances by one.
- R7: Every group holds min(remaining, VLEN/width) elements. The final group holds only what is left, and the job stops when nothing remains.
- R8: Output slots at or above the group's active element count are written as zero.
- R9: Each element moves whole at its width (1, 2, 4 or 8 bytes) into the slot the walk selects.
- R10: `done_o` is high for exactly one cycle, the cycle right after the last buffer write. `busy_o` is high from the cycle after start is accepted through the done cycle.
- R11: A start pulse while `busy_o` is high is ignored. The running job completes unchanged, and no further activity follows its done pulse.
- R12: A job with vector length zero does no reads and no writes. It raises `done_o` in the cycle after start.
- R13: Out of reset, `busy_o`, `done_o`, `rd_en_o` and `wr_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; job parameters sampled with it |
| ew_i | input | 2 | Element width code (0:8, 1:16, 2:32, 3:64 bits) |
| nf_enc_i | input | 3 | Field count minus one |
| vl_i | input | VL_W | Active vector length in elements |
| base_reg_i | input | RF_AW | First source register of field 0 |
| rd_en_o | output | 1 | Register-file read strobe |
| rd_addr_o | output | RF_AW | Register-file read address |
| rd_data_i | input | VLEN | Register-file read data, same cycle |
| wr_valid_o | output | 1 | Buffer register write strobe |
| wr_idx_o | output | BUF_AW | Buffer register index |
| wr_data_o | output | VLEN | Interleaved buffer register contents |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench keeps the default parameters: VLEN of 128, 32 registers and 8-bit vector length. With these, an 8-bit element gives sixteen slots per register and a 64-bit element only two. That brings into reach both walks that wrap across many fields within one register and multi-group jobs with up to eight chunks. Field counts from two to eight are combined with chunk counts whose product stays within eight registers, as a legal segment store demands. Partial final groups leave zeroed tail slots. Start offsets that are not zero in later chunks come up in every multi-field job.

// File: rtl/segst_pkg.sv
`timescale 1ns/1ps
package segst_pkg;

  localparam int SEG_MAX_NF = 8;
  localparam int SEG_NF_W   = $clog2(SEG_MAX_NF);

  typedef enum logic [1:0] {
    EW8  = 2'd0,
    EW16 = 2'd1,
    EW32 = 2'd2,
    EW64 = 2'd3
  } ew_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } seg_state_e;

endpackage

// File: rtl/segst_walk.sv
`timescale 1ns/1ps
// Round-robin walk over the captured field registers: one step per slot.
module segst_walk
  import segst_pkg::*;
#(
  parameter int MAX_EL = 16,
  parameter int EL_W   = $clog2(MAX_EL) + 1
) (
  input  logic [SEG_NF_W-1:0]                nfm1_i,
  input  logic [SEG_NF_W-1:0]                start_src_i,
  input  logic [EL_W-1:0]                    start_idx_i,
  input  logic [EL_W-1:0]                    elem_cnt_i,
  output logic [MAX_EL-1:0][SEG_NF_W-1:0]    slot_src_o,
  output logic [MAX_EL-1:0][EL_W-1:0]        slot_idx_o,
  output logic [SEG_NF_W-1:0]                end_src_o,
  output logic [EL_W-1:0]                    end_idx_o
);

  logic [SEG_NF_W-1:0] src_chain [MAX_EL+1];
  logic [EL_W-1:0]     idx_chain [MAX_EL+1];

  assign src_chain[0] = start_src_i;
  assign idx_chain[0] = start_idx_i;

  for (genvar k = 0; k < MAX_EL; k++) begin : g_step
    logic wrap;
    assign wrap             = (src_chain[k] == nfm1_i);
    assign src_chain[k+1]   = wrap ? '0 : src_chain[k] + SEG_NF_W'(1);
    assign idx_chain[k+1]   = wrap ? idx_chain[k] + EL_W'(1) : idx_chain[k];
    assign slot_src_o[k]    = src_chain[k];
    assign slot_idx_o[k]    = idx_chain[k];
  end

  // Position after the chunk's active slots: start of the next chunk.
  always_comb begin
    end_src_o = src_chain[0];
    end_idx_o = idx_chain[0];
    for (int k = 0; k <= MAX_EL; k++) begin
      if (elem_cnt_i == EL_W'(k)) begin
        end_src_o = src_chain[k];
        end_idx_o = idx_chain[k];
      end
    end
  end

endmodule

// File: rtl/segst_gather.sv
`timescale 1ns/1ps
// Capture buffer for one register group plus per-width element gather.
module segst_gather
  import segst_pkg::*;
#(
  parameter int VLEN   = 128,
  parameter int MAX_EL = VLEN / 8,
  parameter int EL_W   = $clog2(MAX_EL) + 1
) (
  input  logic                               clk,
  input  logic                               cap_en_i,
  input  logic [SEG_NF_W-1:0]                cap_sel_i,
  input  logic [VLEN-1:0]                    rd_data_i,
  input  logic [1:0]                         ew_i,
  input  logic [EL_W-1:0]                    elem_cnt_i,
  input  logic [MAX_EL-1:0][SEG_NF_W-1:0]    slot_src_i,
  input  logic [MAX_EL-1:0][EL_W-1:0]        slot_idx_i,
  output logic [VLEN-1:0]                    data_o
);

  logic [VLEN-1:0] cap_q [SEG_MAX_NF];

  // Data-only storage: enabled load, no reset needed.
  always_ff @(posedge clk) begin
    if (cap_en_i) begin
      cap_q[cap_sel_i] <= rd_data_i;
    end
  end

  for (genvar w = 0; w < 4; w++) begin : g_ew
    localparam int EB = 8 << w;
    localparam int NS = VLEN / EB;
    logic [VLEN-1:0] lane;
    always_comb begin
      lane = '0;
      for (int k = 0; k < NS; k++) begin
        if (k < int'(elem_cnt_i)) begin
          lane[k*EB +: EB] = cap_q[slot_src_i[k]][int'(slot_idx_i[k])*EB +: EB];
        end
      end
    end
  end

  always_comb begin
    unique case (ew_e'(ew_i))
      EW8:     data_o = g_ew[0].lane;
      EW16:    data_o = g_ew[1].lane;
      EW32:    data_o = g_ew[2].lane;
      default: data_o = g_ew[3].lane;
    endcase
  end

endmodule

// File: rtl/segst_ctrl.sv
`timescale 1ns/1ps
// Sequencer: group loop, field reads, chunk writes, walk start tracking.
module segst_ctrl
  import segst_pkg::*;
#(
  parameter int MAX_EL = 16,
  parameter int EL_W   = $clog2(MAX_EL) + 1,
  parameter int VL_W   = 8,
  parameter int RF_AW  = 5,
  parameter int BUF_AW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [1:0]           ew_i,
  input  logic [2:0]           nf_enc_i,
  input  logic [VL_W-1:0]      vl_i,
  input  logic [RF_AW-1:0]     base_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 rd_en_o,
  output logic [RF_AW-1:0]     rd_addr_o,
  output logic                 cap_en_o,
  output logic [SEG_NF_W-1:0]  cap_sel_o,
  output logic                 wr_valid_o,
  output logic [BUF_AW-1:0]    wr_idx_o,
  output logic [1:0]           ew_o,
  output logic [SEG_NF_W-1:0]  nfm1_o,
  output logic [EL_W-1:0]      elem_cnt_o,
  output logic [SEG_NF_W-1:0]  walk_src_o,
  output logic [EL_W-1:0]      walk_idx_o,
  input  logic [SEG_NF_W-1:0]  walk_end_src_i,
  input  logic [EL_W-1:0]      walk_end_idx_i
);

  localparam int LOG_EL = $clog2(MAX_EL);

  seg_state_e          state_q, state_d;
  logic [1:0]          ew_q, ew_d;
  logic [SEG_NF_W-1:0] nfm1_q, nfm1_d;
  logic [VL_W-1:0]     rem_q, rem_d;
  logic [RF_AW-1:0]    nch_q, nch_d;
  logic [RF_AW-1:0]    base_q, base_d;
  logic [SEG_NF_W-1:0] fld_q, fld_d;
  logic [SEG_NF_W-1:0] chk_q, chk_d;
  logic [RF_AW-1:0]    rd_off_q, rd_off_d;
  logic [RF_AW-1:0]    grp_q, grp_d;
  logic [BUF_AW-1:0]   wr_base_q, wr_base_d;
  logic [SEG_NF_W-1:0] src_q, src_d;
  logic [EL_W-1:0]     idx_q, idx_d;

  logic [VL_W:0]       vlmax_in;
  logic [VL_W:0]       nch_calc;
  logic [VL_W-1:0]     vlmax_cur;
  logic [VL_W-1:0]     elem_cnt;
  logic [VL_W-1:0]     rem_after;

  assign vlmax_in  = (VL_W+1)'(MAX_EL) >> ew_i;
  assign nch_calc  = ({1'b0, vl_i} + vlmax_in - (VL_W+1)'(1)) >> (LOG_EL - int'(ew_i));
  assign vlmax_cur = VL_W'(MAX_EL) >> ew_q;
  assign elem_cnt  = (rem_q < vlmax_cur) ? rem_q : vlmax_cur;
  assign rem_after = rem_q - elem_cnt;

  always_comb begin
    state_d   = state_q;
    ew_d      = ew_q;
    nfm1_d    = nfm1_q;
    rem_d     = rem_q;
    nch_d     = nch_q;
    base_d    = base_q;
    fld_d     = fld_q;
    chk_d     = chk_q;
    rd_off_d  = rd_off_q;
    grp_d     = grp_q;
    wr_base_d = wr_base_q;
    src_d     = src_q;
    idx_d     = idx_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          ew_d      = ew_i;
          nfm1_d    = nf_enc_i;
          rem_d     = vl_i;
          nch_d     = RF_AW'(nch_calc);
          base_d    = base_i;
          fld_d     = '0;
          rd_off_d  = '0;
          grp_d     = '0;
          wr_base_d = '0;
          state_d   = (vl_i == '0) ? ST_FIN : ST_READ;
        end
      end
      ST_READ: begin
        fld_d    = fld_q + SEG_NF_W'(1);
        rd_off_d = rd_off_q + nch_q;
        if (fld_q == nfm1_q) begin
          state_d = ST_WRITE;
          chk_d   = '0;
          src_d   = '0;
          idx_d   = '0;
        end
      end
      ST_WRITE: begin
        chk_d = chk_q + SEG_NF_W'(1);
        src_d = walk_end_src_i;
        idx_d = walk_end_idx_i;
        if (chk_q == nfm1_q) begin
          rem_d     = rem_after;
          grp_d     = grp_q + RF_AW'(1);
          rd_off_d  = grp_q + RF_AW'(1);
          wr_base_d = wr_base_q + BUF_AW'(nfm1_q) + BUF_AW'(1);
          fld_d     = '0;
          state_d   = (rem_after == '0) ? ST_FIN : ST_READ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ew_q      <= '0;
      nfm1_q    <= '0;
      rem_q     <= '0;
      nch_q     <= '0;
      base_q    <= '0;
      fld_q     <= '0;
      chk_q     <= '0;
      rd_off_q  <= '0;
      grp_q     <= '0;
      wr_base_q <= '0;
      src_q     <= '0;
      idx_q     <= '0;
    end else begin
      state_q   <= state_d;
      ew_q      <= ew_d;
      nfm1_q    <= nfm1_d;
      rem_q     <= rem_d;
      nch_q     <= nch_d;
      base_q    <= base_d;
      fld_q     <= fld_d;
      chk_q     <= chk_d;
      rd_off_q  <= rd_off_d;
      grp_q     <= grp_d;
      wr_base_q <= wr_base_d;
      src_q     <= src_d;
      idx_q     <= idx_d;
    end
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_FIN);
  assign rd_en_o    = (state_q == ST_READ);
  assign rd_addr_o  = base_q + rd_off_q;
  assign cap_en_o   = (state_q == ST_READ);
  assign cap_sel_o  = fld_q;
  assign wr_valid_o = (state_q == ST_WRITE);
  assign wr_idx_o   = wr_base_q + BUF_AW'(chk_q);
  assign ew_o       = ew_q;
  assign nfm1_o     = nfm1_q;
  assign elem_cnt_o = EL_W'(elem_cnt);
  assign walk_src_o = src_q;
  assign walk_idx_o = idx_q;

  // R3: reading and writing never share a cycle.
  a_r3_read_write_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> !wr_valid_o);

  // R5: a chunk's walk starts on a field that exists.
  a_r5_walk_start_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (src_q <= nfm1_q));

  // R7: every written group carries at least one element and no more than remain.
  a_r7_group_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (elem_cnt != '0) && (elem_cnt <= rem_q));

  // R10: done rises only after a write or straight after an empty start.
  a_r10_done_follows_last_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(wr_valid_o) || $past(state_q == ST_IDLE)));

  // R10: done is a single-cycle pulse.
  a_r10_done_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R11: the job's parameters hold while busy.
  a_r11_params_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> ($stable(base_q) && $stable(nfm1_q) && $stable(ew_q) && $stable(nch_q)));

endmodule

// File: rtl/segst_interleave.sv
`timescale 1ns/1ps
// Field-major to struct-major reorder ahead of a segmented unit-stride store.
module segst_interleave
  import segst_pkg::*;
#(
  parameter int VLEN   = 128,
  parameter int RF_AW  = 5,
  parameter int BUF_AW = 6,
  parameter int VL_W   = $clog2(VLEN) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        ew_i,
  input  logic [2:0]        nf_enc_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [RF_AW-1:0]  base_reg_i,
  output logic              rd_en_o,
  output logic [RF_AW-1:0]  rd_addr_o,
  input  logic [VLEN-1:0]   rd_data_i,
  output logic              wr_valid_o,
  output logic [BUF_AW-1:0] wr_idx_o,
  output logic [VLEN-1:0]   wr_data_o,
  output logic              busy_o,
  output logic              done_o
);

  localparam int MAX_EL = VLEN / 8;
  localparam int EL_W   = $clog2(MAX_EL) + 1;

  logic                             cap_en;
  logic [SEG_NF_W-1:0]              cap_sel;
  logic [1:0]                       ew_cur;
  logic [SEG_NF_W-1:0]              nfm1;
  logic [EL_W-1:0]                  elem_cnt;
  logic [SEG_NF_W-1:0]              walk_src;
  logic [EL_W-1:0]                  walk_idx;
  logic [SEG_NF_W-1:0]              end_src;
  logic [EL_W-1:0]                  end_idx;
  logic [MAX_EL-1:0][SEG_NF_W-1:0]  slot_src;
  logic [MAX_EL-1:0][EL_W-1:0]      slot_idx;

  segst_ctrl #(
    .MAX_EL (MAX_EL),
    .EL_W   (EL_W),
    .VL_W   (VL_W),
    .RF_AW  (RF_AW),
    .BUF_AW (BUF_AW)
  ) i_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .ew_i           (ew_i),
    .nf_enc_i       (nf_enc_i),
    .vl_i           (vl_i),
    .base_i         (base_reg_i),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .rd_en_o        (rd_en_o),
    .rd_addr_o      (rd_addr_o),
    .cap_en_o       (cap_en),
    .cap_sel_o      (cap_sel),
    .wr_valid_o     (wr_valid_o),
    .wr_idx_o       (wr_idx_o),
    .ew_o           (ew_cur),
    .nfm1_o         (nfm1),
    .elem_cnt_o     (elem_cnt),
    .walk_src_o     (walk_src),
    .walk_idx_o     (walk_idx),
    .walk_end_src_i (end_src),
    .walk_end_idx_i (end_idx)
  );

  segst_walk #(
    .MAX_EL (MAX_EL),
    .EL_W   (EL_W)
  ) i_walk (
    .nfm1_i      (nfm1),
    .start_src_i (walk_src),
    .start_idx_i (walk_idx),
    .elem_cnt_i  (elem_cnt),
    .slot_src_o  (slot_src),
    .slot_idx_o  (slot_idx),
    .end_src_o   (end_src),
    .end_idx_o   (end_idx)
  );

  segst_gather #(
    .VLEN   (VLEN),
    .MAX_EL (MAX_EL),
    .EL_W   (EL_W)
  ) i_gather (
    .clk        (clk),
    .cap_en_i   (cap_en),
    .cap_sel_i  (cap_sel),
    .rd_data_i  (rd_data_i),
    .ew_i       (ew_cur),
    .elem_cnt_i (elem_cnt),
    .slot_src_i (slot_src),
    .slot_idx_i (slot_idx),
    .data_o     (wr_data_o)
  );

endmodule

// File: tb/test_segst_interleave.sv
`timescale 1ns/1ps
module test_segst_interleave;

  localparam int VLEN   = 128;
  localparam int RF_AW  = 5;
  localparam int BUF_AW = 6;
  localparam int VL_W   = 8;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [1:0]        ew;
  logic [2:0]        nf_enc;
  logic [VL_W-1:0]   vl;
  logic [RF_AW-1:0]  base;
  logic              rd_en;
  logic [RF_AW-1:0]  rd_addr;
  logic [VLEN-1:0]   rd_data;
  logic              wr_valid;
  logic [BUF_AW-1:0] wr_idx;
  logic [VLEN-1:0]   wr_data;
  logic              busy;
  logic              done;

  logic [VLEN-1:0] rf [32];
  assign rd_data = rf[rd_addr];

  int checks;
  int errors;

  int              rd_log  [64];
  int              wr_ilog [64];
  int              wr_cyc  [64];
  logic [VLEN-1:0] wr_dlog [64];
  int              n_rd;
  int              n_wr;
  int              done_cyc;

  segst_interleave #(
    .VLEN   (VLEN),
    .RF_AW  (RF_AW),
    .BUF_AW (BUF_AW),
    .VL_W   (VL_W)
  ) i_segst_interleave (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .ew_i       (ew),
    .nf_enc_i   (nf_enc),
    .vl_i       (vl),
    .base_reg_i (base),
    .rd_en_o    (rd_en),
    .rd_addr_o  (rd_addr),
    .rd_data_i  (rd_data),
    .wr_valid_o (wr_valid),
    .wr_idx_o   (wr_idx),
    .wr_data_o  (wr_data),
    .busy_o     (busy),
    .done_o     (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] elem_of(logic [VLEN-1:0] r, int idx, int bits);
    logic [VLEN-1:0] sh;
    logic [63:0] mask;
    sh   = r >> (idx * bits);
    mask = (bits == 64) ? '1 : ((64'd1 << bits) - 64'd1);
    return sh[63:0] & mask;
  endfunction

  task automatic fill_rf();
    for (int r = 0; r < 32; r++) begin
      for (int w = 0; w < VLEN / 32; w++) rf[r][w*32 +: 32] = $urandom;
    end
  endtask

  task automatic run_job(int sew, int nfe, int vlen_el, int base_r, bit poke);
    int cyc;
    int nf, bits, vlmax, nch, rem, w;
    fill_rf();
    n_rd = 0; n_wr = 0; done_cyc = -1;
    @(negedge clk);
    ew = 2'(sew); nf_enc = 3'(nfe); vl = VL_W'(vlen_el); base = RF_AW'(base_r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (cyc < 1000) begin
      if (rd_en && n_rd < 64) begin rd_log[n_rd] = int'(rd_addr); n_rd++; end
      if (wr_valid && n_wr < 64) begin
        wr_ilog[n_wr] = int'(wr_idx); wr_dlog[n_wr] = wr_data; wr_cyc[n_wr] = cyc; n_wr++;
      end
      if (done) begin done_cyc = cyc; break; end
      if (poke && cyc == 1) begin
        start = 1'b1; ew = 2'd0; nf_enc = 3'd6; vl = VL_W'(3); base = RF_AW'(17);
      end else begin
        start = 1'b0;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    check(done_cyc >= 0, "R10", "job completion seen", done_cyc, 0);
    // Quiet after done: no restart from a start seen while busy.
    for (int q = 0; q < 3; q++) begin
      @(negedge clk);
      check(!busy && !rd_en && !wr_valid, poke ? "R11" : "R10", "idle after done",
            {busy, rd_en, wr_valid}, 0);
    end

    nf    = nfe + 1;
    bits  = 8 << sew;
    vlmax = VLEN / bits;
    nch   = (vlen_el + vlmax - 1) / vlmax;
    if (vlen_el == 0) begin
      check(n_rd == 0 && n_wr == 0, "R12", "no traffic for empty job", n_rd + n_wr, 0);
      check(done_cyc == 0, "R12", "done cycle for empty job", done_cyc, 0);
      return;
    end
    check(n_rd == nf * nch, "R1", "read count", n_rd, nf * nch);
    check(n_wr == nf * nch, "R2", "write count", n_wr, nf * nch);
    for (int r = 0; r < n_rd && r < nf * nch; r++) begin
      int m, j;
      m = r / nf; j = r % nf;
      check(rd_log[r] == (base_r + j * nch + m) % 32, "R3", "read address",
            rd_log[r], (base_r + j * nch + m) % 32);
    end
    rem = vlen_el;
    w = 0;
    for (int m = 0; m < nch; m++) begin
      int e;
      e = (rem < vlmax) ? rem : vlmax;
      for (int c = 0; c < nf; c++) begin
        if (w < n_wr) begin
          check(wr_ilog[w] == c + m * nf, "R4", "buffer index", wr_ilog[w], c + m * nf);
          check(wr_cyc[w] == 2 * nf * m + nf + c, "R4", "write cycle",
                wr_cyc[w], 2 * nf * m + nf + c);
          for (int k = 0; k < vlmax; k++) begin
            logic [63:0] act, exp;
            string tag;
            act = elem_of(wr_dlog[w], k, bits);
            if (k < e) begin
              int g;
              g   = c * e + k;
              exp = elem_of(rf[(base_r + (g % nf) * nch + m) % 32], g / nf, bits);
              if (k == 0)                          tag = "R5";
              else if (m == nch - 1 && k == e - 1) tag = "R7";
              else if (sew != 0)                   tag = "R9";
              else                                 tag = "R6";
            end else begin
              exp = '0;
              tag = "R8";
            end
            check(act == exp, tag, $sformatf("slot %0d of buffer %0d", k, wr_ilog[w]),
                  longint'(act), longint'(exp));
          end
        end
        w++;
      end
      rem -= e;
    end
    if (n_wr > 0)
      check(done_cyc == wr_cyc[n_wr-1] + 1, "R10", "done one cycle after last write",
            done_cyc, wr_cyc[n_wr-1] + 1);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    void'($urandom(32'h5eed_0042));
    start = 1'b0; ew = '0; nf_enc = '0; vl = '0; base = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R13: reset state.
    check(!busy && !done && !rd_en && !wr_valid, "R13", "outputs in reset",
          {busy, done, rd_en, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rd_en && !wr_valid, "R13", "outputs after reset",
          {busy, done, rd_en, wr_valid}, 0);

    run_job(0, 1, 16, 4, 1'b0);   // two fields, one full group
    run_job(0, 7, 16, 0, 1'b0);   // eight fields
    run_job(3, 3, 4, 10, 1'b0);   // 64-bit elements, two groups
    run_job(0, 2, 5, 2, 1'b0);    // partial single group, zero tail
    run_job(1, 1, 20, 8, 1'b0);   // three groups, short last one
    run_job(3, 1, 7, 20, 1'b0);   // four groups, last holds one element
    run_job(2, 4, 0, 3, 1'b0);    // empty job
    run_job(2, 1, 12, 1, 1'b1);   // start pulse while busy

    for (int t = 0; t < 40; t++) begin
      int sew, nf, vlmax, maxch, vlr, nch, bs;
      sew   = int'($urandom % 4);
      nf    = 2 + int'($urandom % 7);
      vlmax = VLEN / (8 << sew);
      maxch = 8 / nf;
      vlr   = 1 + int'($urandom % (maxch * vlmax));
      nch   = (vlr + vlmax - 1) / vlmax;
      bs    = int'($urandom % (33 - nf * nch));
      run_job(sew, nf - 1, vlr, bs, ($urandom % 5) == 0);
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule